// File: doc/BRIEF.md
# Branch and Condition-Logic Issue Stations on a Shared Dispatch Bus

This block sits between a dispatch stage and two small execution units: one that resolves branches and one that executes condition-register logical operations. Both units receive work over one shared dispatch bus, which carries at most one operation per clock. A type bit on the bus routes each operation into one of two private two-entry holding stations. An operation waits in its station until its operand-ready flag is set, either at dispatch or later by a tag-matched wake-up. It then issues to its unit.

The branch station issues strictly in program order. When a branch issues, it reports its reorder-buffer tag and a prediction-correct flag to the completion side. The condition station issues its oldest ready entry, and it may pass an older entry that is still waiting. The two stations work independently, so both can issue in the same cycle, and a branch never waits on an older condition operation. A flush from the completion side empties both stations at once.

Each station is a small state machine over its occupancy, with three states: EMPTY, ONE and FULL. The transitions are:
- EMPTY→ONE on an accepted dispatch.
- ONE→FULL on a dispatch without an issue.
- ONE→EMPTY on an issue without a dispatch.
- FULL→ONE on an issue.
- ONE→ONE when a dispatch and an issue happen together.
- Any state→EMPTY on flush.

Top module: `brcr_dispatch_stations`

## Requirements
- R1: After reset both stations are empty. Both dispatch-ready outputs are high and both issue-valid outputs are low.
- R2: An accepted operation with `disp_is_cr`=0 enters the branch station, and one with `disp_is_cr`=1 enters the condition station. An operation is accepted when `disp_valid` is high, the ready output for its type is high and `flush` is low. At most one operation is accepted per cycle.
- R3: A station's dispatch-ready output is low while it holds two entries. An operation offered to it then is not stored, and that station's other entries are unaffected.
- R4: An entry issues (issue-valid high with its tag) in the first cycle after the clock edge at which it is held with its ready flag set. It never issues in the cycle in which it is being dispatched.
- R5: The branch station issues only its oldest entry. A ready younger branch waits while the older one is not ready.
- R6: `br_issue_pred_ok` carries `disp_pred_ok` for a branch dispatched ready. For a branch made ready by a resolve, it carries `br_res_ok` from the resolve that matched its tag.
- R7: The condition station issues its oldest ready entry. A ready younger entry bypasses a non-ready older one, and when both are ready the older goes first.
- R8: A branch and a condition operation can issue in the same cycle.
- R9: A ready branch issues even while an older condition operation is still waiting.
- R10: While `flush` is high neither station issues and any dispatch is dropped. From the next cycle both stations are empty, and later wake-ups for the flushed tags have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear both stations |
| disp_valid | input | 1 | Operation present on the shared bus |
| disp_is_cr | input | 1 | 0 = branch, 1 = condition logical |
| disp_tag | input | TAG_W | Reorder-buffer tag |
| disp_opnd_rdy | input | 1 | Operands already available at dispatch |
| disp_pred_ok | input | 1 | Prediction-correct flag for a branch dispatched ready |
| br_disp_ready | output | 1 | Branch station can accept |
| cr_disp_ready | output | 1 | Condition station can accept |
| br_res_valid | input | 1 | Branch resolve for a held tag |
| br_res_tag | input | TAG_W | Tag being resolved |
| br_res_ok | input | 1 | Prediction was correct |
| cr_rdy_valid | input | 1 | Operand wake-up for a condition entry |
| cr_rdy_tag | input | TAG_W | Tag being woken |
| br_issue_valid | output | 1 | Branch issues; completion report valid |
| br_issue_tag | output | TAG_W | Tag of the issuing branch |
| br_issue_pred_ok | output | 1 | Prediction-correct flag to completion |
| cr_issue_valid | output | 1 | Condition operation issues |
| cr_issue_tag | output | TAG_W | Tag of the issuing condition operation |

## Verification
The bench fills each station to capacity and offers a ready third operation. A design that stored it would later issue a tag that was never accepted. It holds a ready younger branch behind an unresolved older one, where an out-of-order branch picker would issue early. It also makes a younger condition entry ready first, and then both entries ready together, which exposes a picker that is strictly in order or that prefers the younger entry. Further cases wake both stations in one cycle, let a branch pass a waiting condition entry, and flush during a visible issue with a dispatch on the bus. These catch coupled issue logic, a flush that does not suppress issue, and a dropped dispatch that still lands.

// File: rtl/brcr_pkg.sv
package brcr_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_ONE   = 2'd1,
        OCC_FULL  = 2'd2
    } occ_e;

    function automatic occ_e occ_of(input logic [1:0] n);
        unique case (n)
            2'd0:    return OCC_EMPTY;
            2'd1:    return OCC_ONE;
            default: return OCC_FULL;
        endcase
    endfunction

endpackage

// File: rtl/brcr_dispatch_route.sv
module brcr_dispatch_route (
    input  logic disp_valid,
    input  logic disp_is_cr,
    input  logic flush,
    input  logic br_room,
    input  logic cr_room,
    output logic br_push,
    output logic cr_push
);
    always_comb begin
        br_push = disp_valid && !flush && !disp_is_cr && br_room;
        cr_push = disp_valid && !flush &&  disp_is_cr && cr_room;
    end
endmodule

// File: rtl/brcr_br_station.sv
module brcr_br_station
    import brcr_pkg::*;
#(
    parameter int unsigned TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic             push_rdy,
    input  logic             push_ok,
    input  logic             res_valid,
    input  logic [TAG_W-1:0] res_tag,
    input  logic             res_ok,
    output logic             has_room,
    output logic             iss_valid,
    output logic [TAG_W-1:0] iss_tag,
    output logic             iss_ok
);
    localparam int unsigned SLOTS = 2;

    occ_e             occ_q, occ_d;
    logic [TAG_W-1:0] tag_q [SLOTS];
    logic [TAG_W-1:0] tag_d [SLOTS];
    logic [SLOTS-1:0] rdy_q, rdy_d, ok_q, ok_d;
    logic [1:0]       cnt, keep;

    // outputs: only the head may issue
    always_comb begin
        has_room  = (occ_q != OCC_FULL);
        iss_valid = (occ_q != OCC_EMPTY) && rdy_q[0] && !flush;
        iss_tag   = tag_q[0];
        iss_ok    = ok_q[0];
    end

    // next state
    always_comb begin
        cnt   = occ_q;
        tag_d = tag_q;
        rdy_d = rdy_q;
        ok_d  = ok_q;
        for (int i = 0; i < SLOTS; i++) begin
            if (res_valid && (2'(i) < cnt) && tag_q[i] == res_tag) begin
                rdy_d[i] = 1'b1;
                ok_d[i]  = res_ok;
            end
        end
        keep = cnt;
        if (iss_valid) begin
            tag_d[0] = tag_d[1];
            rdy_d[0] = rdy_d[1];
            ok_d[0]  = ok_d[1];
            keep     = cnt - 2'd1;
        end
        if (push) begin
            tag_d[keep[0]] = push_tag;
            rdy_d[keep[0]] = push_rdy;
            ok_d[keep[0]]  = push_ok;
            keep           = keep + 2'd1;
        end
        unique case (occ_q)
            OCC_EMPTY, OCC_ONE, OCC_FULL: occ_d = flush ? OCC_EMPTY : occ_of(keep);
            default:                      occ_d = OCC_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= OCC_EMPTY;
            rdy_q <= '0;
            ok_q  <= '0;
            for (int i = 0; i < SLOTS; i++) tag_q[i] <= '0;
        end else begin
            occ_q <= occ_d;
            rdy_q <= rdy_d;
            ok_q  <= ok_d;
            for (int i = 0; i < SLOTS; i++) tag_q[i] <= tag_d[i];
        end
    end
endmodule

// File: rtl/brcr_cr_station.sv
module brcr_cr_station
    import brcr_pkg::*;
#(
    parameter int unsigned TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic             push_rdy,
    input  logic             wake_valid,
    input  logic [TAG_W-1:0] wake_tag,
    output logic             has_room,
    output logic             iss_valid,
    output logic [TAG_W-1:0] iss_tag
);
    localparam int unsigned SLOTS = 2;

    occ_e             occ_q, occ_d;
    logic [TAG_W-1:0] tag_q [SLOTS];
    logic [TAG_W-1:0] tag_d [SLOTS];
    logic [SLOTS-1:0] rdy_q, rdy_d;
    logic [1:0]       cnt, keep;
    logic             pick_old, pick_young;

    // outputs: oldest ready entry wins
    always_comb begin
        cnt        = occ_q;
        has_room   = (occ_q != OCC_FULL);
        pick_old   = (cnt != 2'd0) && rdy_q[0];
        pick_young = (cnt == 2'd2) && rdy_q[1] && !pick_old;
        iss_valid  = (pick_old || pick_young) && !flush;
        iss_tag    = pick_old ? tag_q[0] : tag_q[1];
    end

    // next state
    always_comb begin
        tag_d = tag_q;
        rdy_d = rdy_q;
        for (int i = 0; i < SLOTS; i++) begin
            if (wake_valid && (2'(i) < cnt) && tag_q[i] == wake_tag)
                rdy_d[i] = 1'b1;
        end
        keep = cnt;
        if (iss_valid) begin
            if (pick_old) begin
                tag_d[0] = tag_d[1];
                rdy_d[0] = rdy_d[1];
            end
            keep = cnt - 2'd1;
        end
        if (push) begin
            tag_d[keep[0]] = push_tag;
            rdy_d[keep[0]] = push_rdy;
            keep           = keep + 2'd1;
        end
        unique case (occ_q)
            OCC_EMPTY, OCC_ONE, OCC_FULL: occ_d = flush ? OCC_EMPTY : occ_of(keep);
            default:                      occ_d = OCC_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= OCC_EMPTY;
            rdy_q <= '0;
            for (int i = 0; i < SLOTS; i++) tag_q[i] <= '0;
        end else begin
            occ_q <= occ_d;
            rdy_q <= rdy_d;
            for (int i = 0; i < SLOTS; i++) tag_q[i] <= tag_d[i];
        end
    end
endmodule

// File: rtl/brcr_dispatch_stations.sv
module brcr_dispatch_stations #(
    parameter int unsigned TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             disp_valid,
    input  logic             disp_is_cr,
    input  logic [TAG_W-1:0] disp_tag,
    input  logic             disp_opnd_rdy,
    input  logic             disp_pred_ok,
    output logic             br_disp_ready,
    output logic             cr_disp_ready,
    input  logic             br_res_valid,
    input  logic [TAG_W-1:0] br_res_tag,
    input  logic             br_res_ok,
    input  logic             cr_rdy_valid,
    input  logic [TAG_W-1:0] cr_rdy_tag,
    output logic             br_issue_valid,
    output logic [TAG_W-1:0] br_issue_tag,
    output logic             br_issue_pred_ok,
    output logic             cr_issue_valid,
    output logic [TAG_W-1:0] cr_issue_tag
);
    logic br_push, cr_push;

    brcr_dispatch_route u_route (
        .disp_valid (disp_valid),
        .disp_is_cr (disp_is_cr),
        .flush      (flush),
        .br_room    (br_disp_ready),
        .cr_room    (cr_disp_ready),
        .br_push    (br_push),
        .cr_push    (cr_push)
    );

    brcr_br_station #(.TAG_W(TAG_W)) u_br (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (br_push),
        .push_tag  (disp_tag),
        .push_rdy  (disp_opnd_rdy),
        .push_ok   (disp_pred_ok),
        .res_valid (br_res_valid),
        .res_tag   (br_res_tag),
        .res_ok    (br_res_ok),
        .has_room  (br_disp_ready),
        .iss_valid (br_issue_valid),
        .iss_tag   (br_issue_tag),
        .iss_ok    (br_issue_pred_ok)
    );

    brcr_cr_station #(.TAG_W(TAG_W)) u_cr (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .push       (cr_push),
        .push_tag   (disp_tag),
        .push_rdy   (disp_opnd_rdy),
        .wake_valid (cr_rdy_valid),
        .wake_tag   (cr_rdy_tag),
        .has_room   (cr_disp_ready),
        .iss_valid  (cr_issue_valid),
        .iss_tag    (cr_issue_tag)
    );
endmodule

// File: rtl/brcr_checker.sv
module brcr_checker #(
    parameter int unsigned TAG_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             disp_valid,
    input logic             disp_is_cr,
    input logic [TAG_W-1:0] disp_tag,
    input logic             br_disp_ready,
    input logic             cr_disp_ready,
    input logic             br_issue_valid,
    input logic [TAG_W-1:0] br_issue_tag,
    input logic             cr_issue_valid
);
    logic [1:0]       br_n, cr_n, br_wi, cr_wi;
    logic [TAG_W-1:0] br_sh [2];
    logic             br_acc, cr_acc;

    always_comb begin
        br_acc = disp_valid && !disp_is_cr && br_disp_ready && !flush;
        cr_acc = disp_valid &&  disp_is_cr && cr_disp_ready && !flush;
        br_wi  = br_issue_valid ? br_n - 2'd1 : br_n;
        cr_wi  = cr_issue_valid ? cr_n - 2'd1 : cr_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            br_n     <= '0;
            cr_n     <= '0;
            br_sh[0] <= '0;
            br_sh[1] <= '0;
        end else begin
            if (br_issue_valid) br_sh[0] <= br_sh[1];
            if (br_acc) br_sh[br_wi[0]] <= disp_tag;
            br_n <= br_wi + {1'b0, br_acc};
            cr_n <= cr_wi + {1'b0, cr_acc};
        end
    end

    a_r3_br_ready_tracks_fill: assert property (@(posedge clk) disable iff (!rst_n)
        br_disp_ready == (br_n != 2'd2));
    a_r3_cr_ready_tracks_fill: assert property (@(posedge clk) disable iff (!rst_n)
        cr_disp_ready == (cr_n != 2'd2));
    a_r4_br_issue_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
        br_issue_valid |-> br_n != 2'd0);
    a_r4_cr_issue_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
        cr_issue_valid |-> cr_n != 2'd0);
    a_r5_br_oldest_first: assert property (@(posedge clk) disable iff (!rst_n)
        br_issue_valid |-> br_issue_tag == br_sh[0]);
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> br_disp_ready && cr_disp_ready && !br_issue_valid && !cr_issue_valid);
endmodule

bind brcr_dispatch_stations brcr_checker #(.TAG_W(TAG_W)) u_brcr_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush          (flush),
    .disp_valid     (disp_valid),
    .disp_is_cr     (disp_is_cr),
    .disp_tag       (disp_tag),
    .br_disp_ready  (br_disp_ready),
    .cr_disp_ready  (cr_disp_ready),
    .br_issue_valid (br_issue_valid),
    .br_issue_tag   (br_issue_tag),
    .cr_issue_valid (cr_issue_valid)
);

// File: tb/test_brcr_dispatch_stations.sv
`timescale 1ns/1ps
module test_brcr_dispatch_stations;
    localparam int unsigned TAG_W = 6;

    logic             clk = 1'b0;
    logic             rst_n, flush, disp_valid, disp_is_cr, disp_opnd_rdy, disp_pred_ok;
    logic [TAG_W-1:0] disp_tag, br_res_tag, cr_rdy_tag;
    logic             br_res_valid, br_res_ok, cr_rdy_valid;
    logic             br_disp_ready, cr_disp_ready;
    logic             br_issue_valid, br_issue_pred_ok, cr_issue_valid;
    logic [TAG_W-1:0] br_issue_tag, cr_issue_tag;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    brcr_dispatch_stations #(.TAG_W(TAG_W)) i_brcr_dispatch_stations (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_valid(disp_valid), .disp_is_cr(disp_is_cr), .disp_tag(disp_tag),
        .disp_opnd_rdy(disp_opnd_rdy), .disp_pred_ok(disp_pred_ok),
        .br_disp_ready(br_disp_ready), .cr_disp_ready(cr_disp_ready),
        .br_res_valid(br_res_valid), .br_res_tag(br_res_tag), .br_res_ok(br_res_ok),
        .cr_rdy_valid(cr_rdy_valid), .cr_rdy_tag(cr_rdy_tag),
        .br_issue_valid(br_issue_valid), .br_issue_tag(br_issue_tag),
        .br_issue_pred_ok(br_issue_pred_ok),
        .cr_issue_valid(cr_issue_valid), .cr_issue_tag(cr_issue_tag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        flush = 0; disp_valid = 0; disp_is_cr = 0; disp_tag = '0;
        disp_opnd_rdy = 0; disp_pred_ok = 0;
        br_res_valid = 0; br_res_tag = '0; br_res_ok = 0;
        cr_rdy_valid = 0; cr_rdy_tag = '0;
    endtask

    task automatic put(input logic is_cr, input logic [TAG_W-1:0] tag,
                       input logic rdy, input logic ok);
        disp_valid = 1; disp_is_cr = is_cr; disp_tag = tag;
        disp_opnd_rdy = rdy; disp_pred_ok = ok;
        cyc();
        disp_valid = 0;
    endtask

    task automatic t_reset();
        chk("R1 br ready", br_disp_ready, 1);
        chk("R1 cr ready", cr_disp_ready, 1);
        chk("R1 br issue", br_issue_valid, 0);
        chk("R1 cr issue", cr_issue_valid, 0);
    endtask

    task automatic t_route();
        disp_valid = 1; disp_is_cr = 0; disp_tag = 6'd5; disp_opnd_rdy = 1; disp_pred_ok = 1;
        #0.5;
        chk("R4 no issue while dispatching", br_issue_valid, 0);
        cyc();
        disp_valid = 0;
        chk("R2 branch routed", br_issue_valid, 1);
        chk("R2 branch tag", br_issue_tag, 5);
        chk("R6 dispatch pred flag", br_issue_pred_ok, 1);
        chk("R2 not in cr", cr_issue_valid, 0);
        cyc();
        chk("R4 issued once", br_issue_valid, 0);
        put(1, 6'd9, 1, 0);
        chk("R2 cr routed", cr_issue_valid, 1);
        chk("R2 cr tag", cr_issue_tag, 9);
        chk("R2 not in br", br_issue_valid, 0);
        cyc();
        chk("R4 cr issued once", cr_issue_valid, 0);
    endtask

    task automatic t_full_refuse();
        put(0, 6'd1, 0, 0);
        put(0, 6'd2, 0, 0);
        chk("R3 br full", br_disp_ready, 0);
        chk("R3 cr free", cr_disp_ready, 1);
        put(0, 6'd3, 1, 1);
        chk("R3 no issue", br_issue_valid, 0);
        br_res_valid = 1; br_res_tag = 6'd1; br_res_ok = 0;
        cyc();
        br_res_valid = 0;
        chk("R4 resolved head", br_issue_valid, 1);
        chk("R4 head tag", br_issue_tag, 1);
        chk("R6 resolve flag 0", br_issue_pred_ok, 0);
        cyc();
        chk("R3 second waits", br_issue_valid, 0);
        chk("R3 room again", br_disp_ready, 1);
        br_res_valid = 1; br_res_tag = 6'd2; br_res_ok = 1;
        cyc();
        br_res_valid = 0;
        chk("R3 second tag", br_issue_tag, 2);
        chk("R6 resolve flag 1", br_issue_pred_ok, 1);
        cyc();
        chk("R3 refused op absent", br_issue_valid, 0);
    endtask

    task automatic t_in_order();
        put(0, 6'd10, 0, 0);
        put(0, 6'd11, 1, 1);
        chk("R5 younger held", br_issue_valid, 0);
        cyc();
        chk("R5 younger still held", br_issue_valid, 0);
        br_res_valid = 1; br_res_tag = 6'd10; br_res_ok = 1;
        cyc();
        br_res_valid = 0;
        chk("R5 older first", br_issue_tag, 10);
        chk("R5 older valid", br_issue_valid, 1);
        cyc();
        chk("R5 younger next", br_issue_tag, 11);
        chk("R5 younger valid", br_issue_valid, 1);
        cyc();
        chk("R5 drained", br_issue_valid, 0);
    endtask

    task automatic t_cr_bypass();
        put(1, 6'd20, 0, 0);
        put(1, 6'd21, 1, 0);
        chk("R7 bypass valid", cr_issue_valid, 1);
        chk("R7 bypass tag", cr_issue_tag, 21);
        cyc();
        chk("R7 older waits", cr_issue_valid, 0);
        disp_valid = 1; disp_is_cr = 1; disp_tag = 6'd22; disp_opnd_rdy = 1;
        cr_rdy_valid = 1; cr_rdy_tag = 6'd20;
        cyc();
        disp_valid = 0; cr_rdy_valid = 0;
        chk("R7 both ready older first", cr_issue_tag, 20);
        chk("R7 older valid", cr_issue_valid, 1);
        cyc();
        chk("R7 younger after", cr_issue_tag, 22);
        cyc();
        chk("R7 drained", cr_issue_valid, 0);
    endtask

    task automatic t_concurrent();
        put(0, 6'd30, 0, 0);
        put(1, 6'd31, 0, 0);
        br_res_valid = 1; br_res_tag = 6'd30; br_res_ok = 0;
        cr_rdy_valid = 1; cr_rdy_tag = 6'd31;
        cyc();
        br_res_valid = 0; cr_rdy_valid = 0;
        chk("R8 br issues", br_issue_valid, 1);
        chk("R8 cr issues", cr_issue_valid, 1);
        chk("R8 br tag", br_issue_tag, 30);
        chk("R8 cr tag", cr_issue_tag, 31);
        cyc();
        chk("R8 both drained", {br_issue_valid, cr_issue_valid}, 0);
    endtask

    task automatic t_br_past_cr();
        put(1, 6'd40, 0, 0);
        put(0, 6'd41, 1, 1);
        chk("R9 branch passes", br_issue_valid, 1);
        chk("R9 branch tag", br_issue_tag, 41);
        chk("R9 cr still waiting", cr_issue_valid, 0);
        cyc();
        chk("R9 branch gone", br_issue_valid, 0);
    endtask

    task automatic t_flush();
        put(0, 6'd50, 0, 0);
        put(0, 6'd51, 0, 0);
        put(1, 6'd52, 0, 0);
        chk("R10 pre br full", br_disp_ready, 0);
        chk("R10 pre cr full", cr_disp_ready, 0);
        cr_rdy_valid = 1; cr_rdy_tag = 6'd40;
        cyc();
        cr_rdy_valid = 0;
        chk("R10 cr visible", cr_issue_valid, 1);
        flush = 1;
        disp_valid = 1; disp_is_cr = 0; disp_tag = 6'd53; disp_opnd_rdy = 1; disp_pred_ok = 1;
        #0.5;
        chk("R10 no issue during flush", cr_issue_valid, 0);
        cyc();
        flush = 0; disp_valid = 0;
        chk("R10 br empty", br_disp_ready, 1);
        chk("R10 cr empty", cr_disp_ready, 1);
        chk("R10 dropped dispatch", br_issue_valid, 0);
        br_res_valid = 1; br_res_tag = 6'd50; br_res_ok = 1;
        cr_rdy_valid = 1; cr_rdy_tag = 6'd52;
        cyc();
        br_res_valid = 0; cr_rdy_valid = 0;
        chk("R10 stale br wake", br_issue_valid, 0);
        chk("R10 stale cr wake", cr_issue_valid, 0);
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        quiet();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc();
        t_reset();
        t_route();
        t_full_refuse();
        t_in_order();
        t_cr_bypass();
        t_concurrent();
        t_br_past_cr();
        t_flush();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule